// File: doc/BRIEF.md
# Binary Image Pattern Match Pipeline

This block scores how well an 8×8 one-bit-per-pixel reference pattern matches an 8×8 window of a larger bilevel image. Software first writes the eight pattern rows as words. It then streams image rows, one per word, down a single 8-pixel-wide column strip of the image. Each accepted image row moves the window down by one line. After every move the block reports how many of the 64 window pixels equal the pattern pixel at the same place, so the result lies between 0 and 64. Software covers the whole image by sending the strips of each column offset in turn.

The count is built by a systolic chain of eight stages, one for each pattern row. Every image row that arrives is compared with all eight pattern rows at the same moment. Stage k adds the number of agreeing pixels for its own row to the partial sum it receives from stage k-1, and the chain only moves when a word is written. When the eighth row of a window arrives, the last stage holds the full total. A small sequencer tracks pattern loading and pipeline priming, and it raises the result-valid flag.

The sequencer has four states. `ST_EMPTY` follows reset. `ST_LOADING` holds while pattern rows are still arriving. `ST_PRIMING` means the pattern is complete and fewer than eight image rows have been taken. `ST_READY` means results are valid. The transitions are as follows. Any pattern write moves to `ST_LOADING`, or to `ST_PRIMING` if it was the eighth pattern row; this "pattern restart" transition applies from every state. The eighth image row accepted in `ST_PRIMING` moves to `ST_READY`. In all other cases the state is held.

Top module: `pm_match_top`

## Requirements
- R1: After reset, result_valid is 0 and rd_data is 0.
- R2: A write with pat_mode=1 stores wr_data[7:0] as the next pattern row. Rows are taken in order 0 to 7, bit c of the word is column c, and wr_data[31:8] is ignored.
- R3: A write with pat_mode=0, made after the pattern is complete, takes wr_data[7:0] as the newest image row (bit c = column c; bits 31:8 ignored). The window is the eight most recent image rows, with the oldest aligned to pattern row 0 and the newest to pattern row 7.
- R4: The result is the number of window pixels equal to the pattern pixel in the same row and column: the sum over the rows of popcount(XNOR of pattern row and window row). It ranges from 0 (every pixel differs) to 64 (every pixel agrees).
- R5: result_valid rises at the clock edge that accepts the eighth image row after the pattern is complete, and it shows that window's count at the same edge. Each later image write gives the next window's count one edge after its strobe, with no further latency.
- R6: rd_data carries the 7-bit count zero-extended to 32 bits, and reads 0 whenever result_valid is 0.
- R7: In a cycle with wr_en low, rd_data and result_valid do not change.
- R8: Image writes made before the eight pattern rows are complete do not count toward the eight rows needed for a valid result, and rd_data stays 0.
- R9: A pattern write at any time starts loading again at row 0 and clears result_valid at that edge. After the reload, eight new image rows are needed before the next valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe; the pipeline advances only when it is high |
| pat_mode | input | 1 | 1: the word is a pattern row; 0: the word is an image row |
| wr_data | input | 32 | Write word; only bits 7:0 carry pixels |
| rd_data | output | 32 | Zero-extended match count of the current window |
| result_valid | output | 1 | High when rd_data holds a count for a complete window |

## Verification
The hardest situation to reach is a pattern reload that interrupts a stream already producing results, mixed with image writes that arrive while the new pattern is only partly written. Those writes must neither advance the priming count nor disturb the outputs. The stimulus drives the block into the ready state, writes three pattern rows, sends image rows, finishes the pattern, and then counts strobes exactly up to the seventh and eighth accepted rows. Near-exhaustive sweeps stream a few hundred rows, including all 256 row values, against asymmetric patterns. These sweeps expose any swapped row alignment or column order, and fixed pattern-equal and pattern-inverse streams cover the 64 and 0 limits.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_LOADING,
        ST_PRIMING,
        ST_READY
    } pm_state_e;

endpackage

// File: rtl/pm_row_stage.sv
// One systolic stage: holds one pattern row, adds its agreement count
// for the incoming image row to the partial sum from the previous stage.
module pm_row_stage #(
    parameter int COLS  = 8,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [COLS-1:0]  load_row,
    input  logic             adv,
    input  logic [COLS-1:0]  img_row,
    input  logic [CNT_W-1:0] sum_in,
    output logic [CNT_W-1:0] sum_out
);

    logic [COLS-1:0]  pat_q;
    logic [COLS-1:0]  agree;
    logic [CNT_W-1:0] hits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q <= '0;
        end else if (load_en) begin
            pat_q <= load_row;
        end
    end

    assign agree = ~(pat_q ^ img_row);

    always_comb begin
        hits = '0;
        for (int c = 0; c < COLS; c++) begin
            hits = hits + CNT_W'(agree[c]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_out <= '0;
        end else if (adv) begin
            sum_out <= sum_in + hits;
        end
    end

endmodule

// File: rtl/pm_ctrl.sv
// Sequencer: pattern row indexing, pipeline priming and readiness.
module pm_ctrl
    import pm_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              pat_mode,
    output logic              pat_we,
    output logic [RIDX_W-1:0] pat_row_idx,
    output logic              adv,
    output logic              ready
);

    localparam logic [RIDX_W-1:0] LAST_ROW = RIDX_W'(ROWS - 1);

    pm_state_e         state_q, state_d;
    logic [RIDX_W-1:0] pidx_q;
    logic [RIDX_W-1:0] icnt_q;
    logic [RIDX_W-1:0] row_sel;
    logic              pat_wr;
    logic              img_wr;
    logic              last_pat;

    assign pat_wr   = wr_en & pat_mode;
    assign img_wr   = wr_en & ~pat_mode;
    assign row_sel  = (state_q == ST_LOADING) ? pidx_q : '0;
    assign last_pat = (row_sel == LAST_ROW);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (pat_wr) state_d = last_pat ? ST_PRIMING : ST_LOADING;
            end
            ST_LOADING: begin
                if (pat_wr) state_d = last_pat ? ST_PRIMING : ST_LOADING;
            end
            ST_PRIMING: begin
                if (pat_wr)
                    state_d = last_pat ? ST_PRIMING : ST_LOADING;
                else if (img_wr && icnt_q == LAST_ROW)
                    state_d = ST_READY;
            end
            ST_READY: begin
                if (pat_wr) state_d = last_pat ? ST_PRIMING : ST_LOADING;
            end
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            pidx_q  <= '0;
            icnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (pat_wr) begin
                pidx_q <= row_sel + 1'b1;
                icnt_q <= '0;
            end else if (img_wr && state_q == ST_PRIMING) begin
                icnt_q <= icnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        pat_we      = pat_wr;
        pat_row_idx = row_sel;
        adv         = 1'b0;
        ready       = 1'b0;
        unique case (state_q)
            ST_EMPTY:   adv = 1'b0;
            ST_LOADING: adv = 1'b0;
            ST_PRIMING: adv = img_wr;
            ST_READY: begin
                adv   = img_wr;
                ready = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pm_match_top.sv
module pm_match_top #(
    parameter int WORD_W = 32,
    parameter int ROWS   = 8,
    parameter int COLS   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              pat_mode,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              result_valid
);

    localparam int CNT_W  = $clog2(ROWS * COLS + 1);
    localparam int RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

    logic              pat_we;
    logic [RIDX_W-1:0] pat_row_idx;
    logic              adv;
    logic              ready;
    logic [COLS-1:0]   pix_row;
    logic              unused_hi_bits;
    logic [CNT_W-1:0]  chain [ROWS+1];

    assign pix_row        = wr_data[COLS-1:0];
    assign unused_hi_bits = ^wr_data[WORD_W-1:COLS];
    assign chain[0]       = '0;

    pm_ctrl #(
        .ROWS   (ROWS),
        .RIDX_W (RIDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .pat_mode    (pat_mode),
        .pat_we      (pat_we),
        .pat_row_idx (pat_row_idx),
        .adv         (adv),
        .ready       (ready)
    );

    for (genvar g = 0; g < ROWS; g++) begin : g_stage
        pm_row_stage #(
            .COLS  (COLS),
            .CNT_W (CNT_W)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (pat_we && (pat_row_idx == RIDX_W'(g))),
            .load_row (pix_row),
            .adv      (adv),
            .img_row  (pix_row),
            .sum_in   (chain[g]),
            .sum_out  (chain[g+1])
        );
    end

    assign rd_data      = ready ? WORD_W'(chain[ROWS]) : '0;
    assign result_valid = ready;

endmodule

// File: rtl/pm_match_chk.sv
module pm_match_chk #(
    parameter int WORD_W = 32,
    parameter int ROWS   = 8,
    parameter int COLS   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              pat_mode,
    input logic [WORD_W-1:0] rd_data,
    input logic              result_valid
);

    localparam int MAXC = ROWS * COLS;

    // R6
    zero_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> rd_data == '0);

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data <= WORD_W'(MAXC));

    // R9
    reload_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pat_mode) |=> !result_valid);

    // R7
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rd_data) && $stable(result_valid)));

    // R5
    valid_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> $past(wr_en && !pat_mode));

    // R5
    valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && wr_en && !pat_mode) |=> result_valid);

endmodule

bind pm_match_top pm_match_chk #(
    .WORD_W (WORD_W),
    .ROWS   (ROWS),
    .COLS   (COLS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .pat_mode     (pat_mode),
    .rd_data      (rd_data),
    .result_valid (result_valid)
);

// File: tb/pm_match_top_test.sv
`timescale 1ns/1ps
module pm_match_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        pat_mode = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        result_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model of the requirements
    logic [7:0] pat  [8];
    logic [7:0] hist [8];
    bit  loading  = 0;
    bit  complete = 0;
    int  pidx     = 0;
    int  nacc     = 0;
    logic [15:0] lfsr = 16'hACE1;

    pm_match_top uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .pat_mode     (pat_mode),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .result_valid (result_valid)
    );

    always #2.5 clk = ~clk;

    function automatic int pop8(input logic [7:0] v);
        int n = 0;
        for (int b = 0; b < 8; b++) n += v[b];
        return n;
    endfunction

    function automatic int window_score();
        int s = 0;
        for (int j = 0; j < 8; j++) s += pop8(~(hist[j] ^ pat[j]));
        return s;
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic put(input bit m, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; pat_mode = m; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'hDEAD_BEEF;
    endtask

    task automatic push_pat(input logic [31:0] d);
        put(1'b1, d);
        if (!loading) begin pidx = 0; loading = 1; complete = 0; end
        pat[pidx] = d[7:0];
        pidx++;
        nacc = 0;
        if (pidx == 8) begin loading = 0; complete = 1; end
    endtask

    task automatic push_img(input logic [31:0] d);
        put(1'b0, d);
        if (complete) begin
            for (int j = 0; j < 7; j++) hist[j] = hist[j+1];
            hist[7] = d[7:0];
            nacc++;
        end
    endtask

    task automatic check(input string req);
        logic        ev;
        logic [31:0] ed;
        ev = complete && (nacc >= 8);
        ed = ev ? 32'(window_score()) : 32'd0;
        total++;
        if (result_valid !== ev || rd_data !== ed) begin
            bad++;
            $display("FAIL %s: valid=%0b rd_data=%0d expected valid=%0b rd_data=%0d",
                     req, result_valid, rd_data, ev, ed);
        end
    endtask

    task automatic check_lit(input string req, input logic ev, input logic [31:0] ed);
        total++;
        if (result_valid !== ev || rd_data !== ed) begin
            bad++;
            $display("FAIL %s: valid=%0b rd_data=%0d expected valid=%0b rd_data=%0d",
                     req, result_valid, rd_data, ev, ed);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: valid=%0b rd_data=%0d expected run to end",
                     result_valid, rd_data);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < 8; j++) begin pat[j] = '0; hist[j] = '0; end
        repeat (3) @(negedge clk);
        check_lit("R1 reset", 1'b0, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_lit("R1 after release", 1'b0, 32'd0);

        // R8: image writes with no pattern loaded
        for (int i = 0; i < 3; i++) begin
            push_img(32'h0000_00FF);
            check("R8 no pattern");
        end

        // R2: asymmetric pattern, junk in upper bits
        for (int j = 0; j < 8; j++) push_pat({24'hA5A5A5, 8'(8'h01 << j) ^ 8'(j * 8'h11)});
        check("R2 pattern loaded");

        // R5: seven rows not yet valid, eighth valid
        for (int i = 0; i < 7; i++) begin
            step_lfsr(); push_img({lfsr, lfsr});
            check("R5 priming");
        end
        step_lfsr(); push_img({lfsr, lfsr});
        check_lit("R5 first valid flag", 1'b1, rd_data);
        check("R5 first window");

        // R3/R4: streaming windows
        for (int i = 0; i < 60; i++) begin
            step_lfsr(); push_img({lfsr[7:0], lfsr, lfsr[15:8]});
            check("R3 R4 stream");
        end

        // R7: idle cycles hold outputs
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R7 hold");
        end

        // R4 bounds: equal rows -> 64, inverted rows -> 0
        for (int j = 0; j < 8; j++) push_pat(32'(8'(j * 37 + 5)));
        for (int j = 0; j < 8; j++) push_img(32'(8'(j * 37 + 5)));
        check_lit("R4 all agree", 1'b1, 32'd64);
        for (int j = 0; j < 8; j++) push_img(32'(~8'(j * 37 + 5)));
        check_lit("R4 none agree", 1'b1, 32'd0);

        // R9/R8: reload interrupts a running stream
        for (int j = 0; j < 3; j++) begin
            push_pat(32'(8'(j * 53 + 9)));
            check("R9 reload drops valid");
        end
        for (int i = 0; i < 2; i++) begin
            push_img(32'h0000_003C);
            check("R8 partial pattern");
        end
        for (int j = 3; j < 8; j++) push_pat(32'(8'(j * 53 + 9)));
        for (int i = 0; i < 7; i++) begin
            step_lfsr(); push_img(32'(lfsr));
            check("R9 needs eight new rows");
        end
        step_lfsr(); push_img(32'(lfsr));
        check_lit("R9 valid after refill", 1'b1, rd_data);
        check("R9 refill window");

        // R3/R4/R6: sweep of all 256 row values
        for (int j = 0; j < 8; j++) push_pat(32'(8'(j * 29 + 3)));
        for (int v = 0; v < 256; v++) begin
            push_img({24'hFFFFFF, 8'(v)});
            check("R6 R4 sweep");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule